// File: doc/BRIEF.md
# Serial Port with Single Rate-and-Framing Control Word

This block is an asynchronous serial transmitter and receiver for a memory-mapped bus. Software talks to it through two access points. The data port accepts a character to send on each write strobe. It also shows the oldest received character at all times, and a read strobe removes that character. Each received word carries its own error flags next to the byte, so software can tell which character was damaged.

The bit rate divisor and every framing option sit in one 32-bit control word. The options are word length, parity enable and sense, stop-bit count, a forced-low line, and FIFO depth selection. Three status outputs let software poll the port: receive queue empty, transmit queue full, and transmitter busy. A global enable input shuts the port down. While it is low, both shifters stop, both queues are flushed and the line is held at the idle level.

Top module: `lcr_uart`

## Requirements
- R1: A received word reads as: byte in bits 7:0, framing error in bit 8, parity error in bit 9, overrun in bit 10. A clean character has bits 10:8 clear.
- R2: Control bits 18:0 are stored and read back, and bits 31:19 read as zero. Bits 11:0 hold a divisor q, and each serial bit lasts 16*(q+1) clocks.
- R3: While control bit 12 is set and the port is enabled, the transmit line is driven low.
- R4: Control bit 13 enables a parity bit after the data bits. Bit 14 set selects even parity and bit 14 clear selects odd parity. A received parity bit that does not match sets bit 9 of that word.
- R5: Control bit 15 set sends two stop bits; clear sends one. A receive stop bit sampled low sets bit 8 of that word.
- R6: Control bits 18:17 give the data length: 00 is 5 bits, 01 is 6, 10 is 7, 11 is 8. Only that many bits are sent, and received data bits above the length read as zero.
- R7: Control bit 16 set gives each direction a 16-entry queue; clear gives one entry. The transmit-full output reflects the active capacity.
- R8: A character that completes while the receive queue is full is dropped, and bit 10 is set on the newest stored word.
- R9: The busy output stays high while a character is queued or still shifting, including its last stop bit.
- R10: While enable is low, the transmit line is high, both queues are empty and the busy output is low.
- R11: A frame is one low start bit, then data bits least significant first, then optional parity, then stop bits. The line idles high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low flushes and idles the port |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Current control word |
| tx_we | input | 1 | Transmit character write strobe |
| tx_wdata | input | 8 | Character to send |
| rx_re | input | 1 | Remove the oldest received word |
| rx_rdata | output | 11 | Oldest received word with error flags |
| rx_empty | output | 1 | Receive queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_busy | output | 1 | Transmitter has work queued or in progress |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |

## Verification
The control word, the queue flags and the enable and break effects on the line all settle one clock after the strobe or level change that causes them. The bench samples these two clocks later, on a falling edge. Serial bits are timed in units of 16*(q+1) clocks. The transmit line is sampled half a bit after the observed start edge and then once per bit, so the up-to-q-clock offset before the first oversampling tick falls well inside the sampling margin. A received word is pushed at the middle of its stop bit. The bench reads it only after it has driven a full stop bit and an idle bit, so the word is in place at the time of the read.

// File: rtl/lcr_uart_pkg.sv
package lcr_uart_pkg;
  localparam int CFG_W = 19;
  localparam int DIV_W = 12;

  // Field order matches control word bit positions (MSB first).
  typedef struct packed {
    logic [1:0]       len;
    logic             fifo_on;
    logic             two_stop;
    logic             even;
    logic             par_on;
    logic             brk;
    logic [DIV_W-1:0] div;
  } lcr_cfg_t;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} frame_st_t;

  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction

  // index of the last data bit: 4 + len
  function automatic logic [2:0] last_bit(input logic [1:0] len);
    return {1'b1, len};
  endfunction
endpackage

// File: rtl/lcr_uart_tick.sv
module lcr_uart_tick #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [DW-1:0] div,
  output logic          tick
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/lcr_uart_fifo.sv
module lcr_uart_fifo #(
  parameter int W        = 8,
  parameter int DEPTH    = 16,
  parameter bit MARK_EN  = 1'b0,
  parameter int MARK_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         single,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          do_pop, do_push;

  assign empty   = (cnt == '0);
  assign full    = single ? (cnt != '0) : (cnt >= CAP);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + AW'(1);
      if (do_pop)  rp <= rp + AW'(1);
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end

  generate
    if (MARK_EN) begin : g_mark
      // Dropped push tags the newest stored entry.
      always_ff @(posedge clk) begin
        if (do_push)
          mem[wp] <= din;
        else if (push && !empty)
          mem[wp - AW'(1)][MARK_BIT] <= 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/lcr_uart_tx.sv
module lcr_uart_tx
  import lcr_uart_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       tick,
  input  lcr_cfg_t   cfg,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_data,
  output logic       pop,
  output logic       txd,
  output logic       active
);
  frame_st_t  st;
  logic [7:0] sh, din_m;
  logic       parb, scnt, line;
  logic [3:0] tcnt;
  logic [2:0] bcnt;
  logic       unused_cfg;

  assign unused_cfg = ^{cfg.div, cfg.fifo_on};
  assign din_m  = fifo_data & len_mask(cfg.len);
  assign pop    = en && (st == S_IDLE) && !fifo_empty;
  assign active = (st != S_IDLE);

  always_comb begin
    case (st)
      S_START: line = 1'b0;
      S_DATA:  line = sh[0];
      S_PAR:   line = parb;
      default: line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st <= S_IDLE; sh <= '0; parb <= 1'b0;
      tcnt <= '0; bcnt <= '0; scnt <= 1'b0;
    end else if (st == S_IDLE) begin
      if (pop) begin
        sh   <= din_m;
        parb <= ^din_m ^ ~cfg.even;
        tcnt <= '0; bcnt <= '0; scnt <= 1'b0;
        st   <= S_START;
      end
    end else if (tick) begin
      tcnt <= tcnt + 4'd1;
      if (tcnt == 4'd15) begin
        case (st)
          S_START: st <= S_DATA;
          S_DATA: begin
            sh   <= sh >> 1;
            bcnt <= bcnt + 3'd1;
            if (bcnt == last_bit(cfg.len)) st <= cfg.par_on ? S_PAR : S_STOP;
          end
          S_PAR:   st <= S_STOP;
          S_STOP: begin
            scnt <= 1'b1;
            if (scnt || !cfg.two_stop) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          txd <= 1'b1;
    else if (!en)     txd <= 1'b1;
    else if (cfg.brk) txd <= 1'b0;
    else              txd <= line;
  end
endmodule

// File: rtl/lcr_uart_rx.sv
module lcr_uart_rx
  import lcr_uart_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        tick,
  input  lcr_cfg_t    cfg,
  input  logic        rxd,
  output logic        push,
  output logic [10:0] word
);
  frame_st_t  st;
  logic       s1, s2, perr;
  logic [7:0] sh, aligned;
  logic [3:0] tcnt;
  logic [2:0] bcnt;
  logic       unused_cfg;

  assign unused_cfg = ^{cfg.div, cfg.fifo_on, cfg.two_stop, cfg.brk};
  assign aligned = sh >> (2'd3 - cfg.len);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b1; s2 <= 1'b1;
    end else begin
      s1 <= rxd;  s2 <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      st <= S_IDLE; sh <= '0; tcnt <= '0; bcnt <= '0;
      perr <= 1'b0; push <= 1'b0; word <= '0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!s2) begin
            st <= S_START; tcnt <= '0; perr <= 1'b0;
          end
          S_START: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'd7) begin
              tcnt <= '0; bcnt <= '0;
              st   <= s2 ? S_IDLE : S_DATA;
            end
          end
          S_DATA: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'd15) begin
              sh   <= {s2, sh[7:1]};
              bcnt <= bcnt + 3'd1;
              if (bcnt == last_bit(cfg.len)) st <= cfg.par_on ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'd15) begin
              perr <= ^aligned ^ s2 ^ ~cfg.even;
              st   <= S_STOP;
            end
          end
          S_STOP: begin
            tcnt <= tcnt + 4'd1;
            if (tcnt == 4'd15) begin
              push <= 1'b1;
              word <= {1'b0, perr, ~s2, aligned};
              st   <= S_IDLE;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lcr_uart.sv
module lcr_uart
  import lcr_uart_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        tx_we,
  input  logic [7:0]  tx_wdata,
  input  logic        rx_re,
  output logic [10:0] rx_rdata,
  output logic        rx_empty,
  output logic        tx_full,
  output logic        tx_busy,
  output logic        txd,
  input  logic        rxd
);
  lcr_cfg_t   cfg_q;
  logic       tick, tx_empty, tx_pop, tx_active, rx_push;
  logic [7:0] tx_head;
  logic [10:0] rx_word;
  logic       unused_hi;

  assign unused_hi = ^cfg_wdata[31:CFG_W];

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata[CFG_W-1:0];
  end
  assign cfg_rdata = {{(32-CFG_W){1'b0}}, cfg_q};

  lcr_uart_tick #(.DW(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .en(en), .div(cfg_q.div), .tick(tick)
  );

  lcr_uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH), .MARK_EN(1'b0), .MARK_BIT(0)) u_txq (
    .clk(clk), .rst(rst), .flush(!en), .single(!cfg_q.fifo_on),
    .push(tx_we), .din(tx_wdata), .pop(tx_pop),
    .dout(tx_head), .empty(tx_empty), .full(tx_full)
  );

  lcr_uart_tx u_tx (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .cfg(cfg_q),
    .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop),
    .txd(txd), .active(tx_active)
  );

  lcr_uart_rx u_rx (
    .clk(clk), .rst(rst), .en(en), .tick(tick), .cfg(cfg_q),
    .rxd(rxd), .push(rx_push), .word(rx_word)
  );

  lcr_uart_fifo #(.W(11), .DEPTH(FIFO_DEPTH), .MARK_EN(1'b1), .MARK_BIT(10)) u_rxq (
    .clk(clk), .rst(rst), .flush(!en), .single(!cfg_q.fifo_on),
    .push(rx_push), .din(rx_word), .pop(rx_re),
    .dout(rx_rdata), .empty(rx_empty), .full()
  );

  assign tx_busy = tx_active || !tx_empty;
endmodule

// File: rtl/lcr_uart_chk.sv
module lcr_uart_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        txd,
  input logic        rx_empty,
  input logic        tx_full,
  input logic        tx_busy,
  input logic        cfg_we,
  input logic [31:0] cfg_wdata,
  input logic [31:0] cfg_rdata
);
  // R10
  off_line_high_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> txd);

  // R10
  off_rx_flushed_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> rx_empty);

  // R3
  break_low_chk: assert property (@(posedge clk) disable iff (rst)
    (en && cfg_rdata[12]) |=> !txd);

  // R9
  full_implies_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tx_full |-> tx_busy);

  // R2
  cfg_store_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> cfg_rdata == {13'h0, $past(cfg_wdata[18:0])});
endmodule

bind lcr_uart lcr_uart_chk u_lcr_uart_chk (
  .clk(clk), .rst(rst), .en(en), .txd(txd), .rx_empty(rx_empty),
  .tx_full(tx_full), .tx_busy(tx_busy), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
);

// File: tb/lcr_uart_bench.sv
module lcr_uart_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        tx_we = 1'b0;
  logic [7:0]  tx_wdata = '0;
  logic        rx_re = 1'b0;
  logic [10:0] rx_rdata;
  logic        rx_empty, tx_full, tx_busy, txd;
  logic        rxd = 1'b1;

  int nchk = 0;
  int nerr = 0;
  int bc = 32;
  bit done = 0;

  always #10 clk = ~clk;

  lcr_uart u_lcr_uart (
    .clk(clk), .rst(rst), .en(en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tx_we(tx_we), .tx_wdata(tx_wdata), .rx_re(rx_re),
    .rx_rdata(rx_rdata), .rx_empty(rx_empty), .tx_full(tx_full),
    .tx_busy(tx_busy), .txd(txd), .rxd(rxd)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] mask_of(input int nb);
    return 8'((9'h100 >> (8 - nb)) - 1);
  endfunction

  function automatic logic par_of(input logic [7:0] d, input int nb, input bit even);
    return (^(d & mask_of(nb))) ^ !even;
  endfunction

  task automatic set_cfg(input int q, input int nb, input bit par, input bit even,
                         input bit two, input bit fifo, input bit brk);
    @(negedge clk);
    cfg_wdata = {13'h0, 2'(nb - 5), fifo, two, even, par, brk, 12'(q)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    bc = 16 * (q + 1);
  endtask

  task automatic tx_write(input logic [7:0] b);
    @(negedge clk);
    tx_wdata = b; tx_we = 1'b1;
    @(negedge clk);
    tx_we = 1'b0;
  endtask

  task automatic capture(input int nb, input bit par, output logic [7:0] d,
                         output logic p, output logic stp, output logic busy2);
    int t;
    t = 0;
    d = '0; p = 1'b0;
    while (txd && t < 4000) begin @(negedge clk); t++; end
    clks(bc / 2);
    check(txd == 1'b0, "R11 start bit low", 32'(txd), 0);
    for (int i = 0; i < nb; i++) begin clks(bc); d[i] = txd; end
    if (par) begin clks(bc); p = txd; end
    clks(bc); stp = txd;
    clks(bc); busy2 = tx_busy;
  endtask

  task automatic drive(input logic [7:0] d, input int nb, input bit par, input bit even,
                       input bit flip, input bit stopv);
    @(negedge clk);
    rxd = 1'b0; clks(bc);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; clks(bc); end
    if (par) begin rxd = par_of(d, nb, even) ^ flip; clks(bc); end
    rxd = stopv; clks(bc);
    rxd = 1'b1; clks(bc);
  endtask

  task automatic rx_read(output logic [10:0] w);
    @(negedge clk);
    w = rx_rdata; rx_re = 1'b1;
    @(negedge clk);
    rx_re = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240607));
    forever begin
      @(negedge clk);
      if (done) break;
    end
  end

  initial begin
    clks(200000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d, got;
    logic        p, stp, busy2;
    logic [10:0] w;
    int          lowc, nb, q;
    bit          par, even, two, fifo;

    clks(5);
    rst = 1'b0;
    clks(2);
    // reset state: R11 idle line, R9 not busy, R2 control word clear
    check(txd == 1'b1, "R11 reset idle high", 32'(txd), 1);
    check(rx_empty == 1'b1, "R10 reset rx empty", 32'(rx_empty), 1);
    check(tx_busy == 1'b0 && tx_full == 1'b0, "R9 reset not busy", 32'({tx_busy, tx_full}), 0);
    check(cfg_rdata == 32'h0, "R2 reset control", cfg_rdata, 0);
    en = 1'b1;

    // R2 readback of stored bits only
    set_cfg(4095, 8, 1, 1, 1, 1, 1);
    @(negedge clk);
    cfg_wdata = 32'hFFFF_FFFF; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    check(cfg_rdata == 32'h0007_FFFF, "R2 control readback", cfg_rdata, 32'h0007_FFFF);

    // R2 bit time: 8N1 zero byte gives 9 low bit times
    set_cfg(2, 8, 0, 0, 0, 0, 0);
    tx_write(8'h00);
    lowc = 0;
    while (txd) @(negedge clk);
    while (!txd && lowc < 2000) begin @(negedge clk); lowc++; end
    check(lowc >= 9 * bc - 4 && lowc <= 9 * bc + 1, "R2 bit time", 32'(lowc), 32'(9 * bc));
    clks(2 * bc);

    // random framings, both directions
    for (int it = 0; it < 8; it++) begin
      q = 1 + int'($urandom % 3);
      nb = 5 + int'($urandom % 4);
      par = 1'($urandom); even = 1'($urandom); two = 1'($urandom); fifo = 1'($urandom);
      d = 8'($urandom);
      set_cfg(q, nb, par, even, two, fifo, 0);
      tx_write(d);
      clks(1);
      check(tx_busy == 1'b1, "R9 busy after write", 32'(tx_busy), 1);
      capture(nb, par, got, p, stp, busy2);
      check(got == (d & mask_of(nb)), "R6 R11 tx data", 32'(got), 32'(d & mask_of(nb)));
      if (par) check(p == par_of(d, nb, even), "R4 tx parity", 32'(p), 32'(par_of(d, nb, even)));
      check(stp == 1'b1, "R5 stop high", 32'(stp), 1);
      check(busy2 == two, "R5 R9 second stop busy", 32'(busy2), 32'(two));
      clks(2 * bc);
      drive(d, nb, par, even, 0, 1);
      check(rx_empty == 1'b0, "R1 rx has word", 32'(rx_empty), 0);
      rx_read(w);
      check(w == {3'b000, d & mask_of(nb)}, "R1 R6 rx word", 32'(w), 32'({3'b000, d & mask_of(nb)}));
    end

    // R4 parity error flagged
    set_cfg(1, 8, 1, 1, 0, 0, 0);
    drive(8'hA7, 8, 1, 1, 1, 1);
    rx_read(w);
    check(w == {3'b010, 8'hA7}, "R4 rx parity error", 32'(w), 32'({3'b010, 8'hA7}));
    set_cfg(1, 7, 1, 0, 0, 0, 0);
    drive(8'h35, 7, 1, 0, 0, 1);
    rx_read(w);
    check(w == {3'b000, 8'h35}, "R4 odd parity clean", 32'(w), 32'({3'b000, 8'h35}));

    // R5 framing error
    set_cfg(1, 8, 0, 0, 0, 0, 0);
    drive(8'h5C, 8, 0, 0, 0, 0);
    rx_read(w);
    check(w == {3'b001, 8'h5C}, "R5 R1 framing error", 32'(w), 32'({3'b001, 8'h5C}));

    // R8 overrun in single-entry mode
    drive(8'h11, 8, 0, 0, 0, 1);
    drive(8'h22, 8, 0, 0, 0, 1);
    rx_read(w);
    check(w == {3'b100, 8'h11}, "R8 overrun flag on stored", 32'(w), 32'({3'b100, 8'h11}));
    clks(1);
    check(rx_empty == 1'b1, "R8 dropped char", 32'(rx_empty), 1);

    // R7 queue mode keeps two characters
    set_cfg(1, 8, 0, 0, 0, 1, 0);
    drive(8'h33, 8, 0, 0, 0, 1);
    drive(8'h44, 8, 0, 0, 0, 1);
    rx_read(w);
    check(w == {3'b000, 8'h33}, "R7 queue first", 32'(w), 32'({3'b000, 8'h33}));
    rx_read(w);
    check(w == {3'b000, 8'h44}, "R7 queue second", 32'(w), 32'({3'b000, 8'h44}));
    clks(1);
    check(rx_empty == 1'b1, "R7 queue drained", 32'(rx_empty), 1);

    // R7 tx full in single mode, then R10 flush
    set_cfg(1, 8, 0, 0, 0, 0, 0);
    tx_write(8'h01);
    tx_write(8'h02);
    clks(1);
    check(tx_full == 1'b1, "R7 single tx full", 32'(tx_full), 1);
    check(tx_busy == 1'b1, "R9 busy while queued", 32'(tx_busy), 1);
    en = 1'b0;
    clks(2);
    check(tx_full == 1'b0 && tx_busy == 1'b0, "R10 tx flushed", 32'({tx_full, tx_busy}), 0);
    check(txd == 1'b1, "R10 line high when off", 32'(txd), 1);
    en = 1'b1;

    // R7 sixteen-entry tx queue
    set_cfg(1, 8, 0, 0, 0, 1, 0);
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      tx_wdata = 8'(i); tx_we = 1'b1; @(negedge clk);
    end
    tx_we = 1'b0;
    check(tx_full == 1'b0, "R7 deep queue not full", 32'(tx_full), 0);
    tx_wdata = 8'hEE; tx_we = 1'b1; @(negedge clk);
    tx_we = 1'b0;
    check(tx_full == 1'b1, "R7 deep queue full", 32'(tx_full), 1);
    en = 1'b0; clks(2); en = 1'b1;
    clks(bc);

    // R10 rx flush
    drive(8'h66, 8, 0, 0, 0, 1);
    check(rx_empty == 1'b0, "R10 rx loaded", 32'(rx_empty), 0);
    en = 1'b0; clks(2);
    check(rx_empty == 1'b1, "R10 rx flushed", 32'(rx_empty), 1);
    en = 1'b1;

    // R3 break
    set_cfg(1, 8, 0, 0, 0, 0, 1);
    clks(2);
    check(txd == 1'b0, "R3 break low", 32'(txd), 0);
    clks(40);
    check(txd == 1'b0, "R3 break held", 32'(txd), 0);
    set_cfg(1, 8, 0, 0, 0, 0, 0);
    clks(2);
    check(txd == 1'b1, "R3 break released", 32'(txd), 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule